// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with 17 address bits and a shared 24-bit data bus. The host offers one word at a time over a valid/ready handshake: an address, a write flag and write data. The controller turns each request into a sequence of registered memory strobes. For a read it returns the word with a one-cycle valid pulse. For a write the word is left in the RAM.

The RAM is enabled by three chip-select lines. The first and third are active low and the second is active high. Every timing minimum of the RAM is set as a nanosecond parameter. Each one is turned into a cycle count, `ceil(t / CLK_PERIOD_NS)` with a floor of one cycle, so the same RTL serves any clock period.

A write can keep output enable high during the write pulse, which is the default. It can instead hold output enable low, which needs a longer pulse. The parameter `OE_HIGH_WRITE` picks the variant. In both variants the controller's own data drivers stay off until the RAM is certain to have released the bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request is accepted, the memory is deselected: mem_cs1_n=1, mem_cs2=0, mem_cs3_n=1. Also mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0. req_ready is 0 during reset.
- R2: From the cycle after the first accepted request, the memory stays selected (mem_cs1_n=0, mem_cs2=1, mem_cs3_n=0). Between transactions the idle state is mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and req_ready=1.
- R3: A read accepted at edge E0 drives mem_oe_n=0 and mem_we_n=1 for RD = max(ceil(10/P), ceil(5/P)) cycles, which is 3 at P=4 ns. mem_dq_in is captured at edge E0+RD, and mem_oe_n returns high at that same edge.
- R4: req_ready is low from the cycle after acceptance until the transaction ends. A request held with req_valid high while req_ready is low is accepted once req_ready returns, and no request is lost.
- R5: For a write with OE_HIGH_WRITE=1 (the default), the first ceil(6/P) cycles after acceptance (2 cycles) have mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R6: Next, with OE_HIGH_WRITE=1, mem_we_n=0 and mem_dq_oe=1 for max(ceil(7/P), ceil(5/P)) cycles (2 cycles). One cycle follows with mem_we_n=1 and mem_dq_oe still 1. Then mem_dq_oe=0 and req_ready=1.
- R7: With OE_HIGH_WRITE=0, mem_we_n=0 and mem_oe_n=0 both start at acceptance. mem_dq_oe stays 0 for G = max(ceil(5/P), ceil(6/P)) cycles (2 cycles). mem_dq_oe=1 then follows for max(ceil(5/P), ceil(9/P)-G) cycles (2 cycles). mem_we_n is therefore low for at least ceil(9/P) cycles. The release cycle is the same as in R6.
- R8: During a transaction, mem_addr equals the accepted address. Whenever mem_dq_oe is 1, mem_dq_out equals the accepted write data.
- R9: mem_dq_oe is never 1 while the memory is in read mode (selected, mem_we_n=1, mem_oe_n=0). It is also 0 for the first ceil(6/P) cycles after read mode ends.
- R10: rsp_valid is high for exactly one cycle per read and never for a write. rsp_rdata then holds the word last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 24 | Write data |
| rsp_valid | output | 1 | One-cycle read-data valid |
| rsp_rdata | output | 24 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Chip select 1, active low |
| mem_cs2 | output | 1 | Chip select 2, active high |
| mem_cs3_n | output | 1 | Chip select 3, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 24 | Value for the data pads |
| mem_dq_in | input | 24 | Value read from the data pads |
| mem_dq_oe | output | 1 | Data pad driver enable |

## Verification
Any wrong phase or off-by-one count appears within the same transaction as a strobe edge one cycle early or late. The reference model compares every strobe on every cycle, so such an error is caught on the cycle it occurs. A state that never leaves its phase shows as req_ready staying low, which the following request exposes at once. A shortened access count makes the controller capture data before the memory model presents it, so rsp_rdata is wrong on its valid pulse. Data drivers enabled too early are flagged as contention in the cycle they rise.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WPREP,
    ST_WGAP,
    ST_WDRV,
    ST_WREL
  } ctl_state_e;

  // ceil(t / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, never below one cycle
  function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
    return (a > b + 1) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_C   = 3,
  parameter int unsigned PREP_C = 2,
  parameter int unsigned GAP_C  = 0,
  parameter int unsigned DRV_C  = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic we_n,
  output logic oe_n,
  output logic drv,
  output logic sel
);

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             we_q, we_d, oe_q, oe_d, drv_q, drv_d, sel_q, sel_d;
  logic             rdy_q, rdy_d;
  logic             cnt_zero;

  assign accept   = req_valid & rdy_q;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    we_d    = we_q;
    oe_d    = oe_q;
    drv_d   = drv_q;
    sel_d   = sel_q;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          sel_d = 1'b1;
          if (req_write) begin
            if (PREP_C != 0) begin
              state_d = ST_WPREP;
              cnt_d   = CNT_W'(PREP_C - 1);
              oe_d    = 1'b1;
            end else begin
              state_d = ST_WGAP;
              cnt_d   = CNT_W'(GAP_C - 1);
              we_d    = 1'b0;
              oe_d    = 1'b0;
            end
          end else begin
            state_d = ST_READ;
            cnt_d   = CNT_W'(RD_C - 1);
            oe_d    = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          capture = 1'b1;
          state_d = ST_IDLE;
          oe_d    = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WPREP: begin
        if (cnt_zero) begin
          we_d = 1'b0;
          if (GAP_C != 0) begin
            state_d = ST_WGAP;
            cnt_d   = CNT_W'(GAP_C - 1);
          end else begin
            state_d = ST_WDRV;
            cnt_d   = CNT_W'(DRV_C - 1);
            drv_d   = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WGAP: begin
        if (cnt_zero) begin
          state_d = ST_WDRV;
          cnt_d   = CNT_W'(DRV_C - 1);
          drv_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WDRV: begin
        if (cnt_zero) begin
          state_d = ST_WREL;
          we_d    = 1'b1;
          oe_d    = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WREL: begin
        state_d = ST_IDLE;
        drv_d   = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
    rdy_d = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      drv_q   <= 1'b0;
      sel_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      drv_q   <= drv_d;
      sel_q   <= sel_d;
      rdy_q   <= rdy_d;
    end
  end

  assign req_ready = rdy_q;
  assign we_n      = we_q;
  assign oe_n      = oe_q;
  assign drv       = drv_q;
  assign sel       = sel_q;

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= capture;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = vld_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 24,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter bit          OE_HIGH_WRITE = 1'b1,
  parameter int unsigned T_RC_NS       = 10,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_OE_NS       = 5,
  parameter int unsigned T_OHZ_NS      = 6,
  parameter int unsigned T_WHZ_NS      = 5,
  parameter int unsigned T_WP_OEH_NS   = 7,
  parameter int unsigned T_WP_OEL_NS   = 9,
  parameter int unsigned T_DW_NS       = 5,
  parameter int unsigned T_WC_NS       = 10,
  parameter int unsigned T_AW_NS       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_cs3_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned P      = CLK_PERIOD_NS;
  localparam int unsigned RD_C   = max2(max2(ns_to_cyc(T_RC_NS, P), ns_to_cyc(T_AA_NS, P)),
                                        ns_to_cyc(T_OE_NS, P));
  localparam int unsigned TURN_C = max2(ns_to_cyc(T_OHZ_NS, P), ns_to_cyc(T_WHZ_NS, P));
  localparam int unsigned PREP_C = OE_HIGH_WRITE ? ns_to_cyc(T_OHZ_NS, P) : 0;
  localparam int unsigned GAP_C  = OE_HIGH_WRITE ? 0 : TURN_C;
  localparam int unsigned WP_C   = OE_HIGH_WRITE ? ns_to_cyc(T_WP_OEH_NS, P)
                                                 : ns_to_cyc(T_WP_OEL_NS, P);
  localparam int unsigned DRV_C  = max2(max2(ns_to_cyc(T_DW_NS, P), sub_floor1(WP_C, GAP_C)),
                                        max2(sub_floor1(ns_to_cyc(T_AW_NS, P), GAP_C),
                                             sub_floor1(ns_to_cyc(T_WC_NS, P), PREP_C + GAP_C + 1)));
  localparam int unsigned CNT_MAX = max2(max2(RD_C, PREP_C), max2(GAP_C, DRV_C));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic rst_i_n, accept, capture, sel;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sram_ctrl_fsm #(
    .RD_C   (RD_C),
    .PREP_C (PREP_C),
    .GAP_C  (GAP_C),
    .DRV_C  (DRV_C),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drv       (mem_dq_oe),
    .sel       (sel)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  assign mem_cs1_n = ~sel;
  assign mem_cs2   = sel;
  assign mem_cs3_n = ~sel;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  // R4
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && $past(mem_we_n)));

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (($past(mem_oe_n) && $past(mem_oe_n, 2)) ||
                          ($past(!mem_we_n) && $past(!mem_we_n, 2))));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  // R9
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n || !mem_we_n));

  // R2
  stay_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs2 |=> mem_cs2);

endmodule

bind sram_seq_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs2   (mem_cs2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;

  localparam int NOPS = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        req_valid [2], req_write [2], req_ready [2], rsp_valid [2];
  logic [16:0] req_addr [2], mem_addr [2];
  logic [23:0] req_wdata [2], rsp_rdata [2], mem_dq_out [2], mem_dq_in [2];
  logic        cs1_n [2], cs2 [2], cs3_n [2], we_n [2], oe_n [2], dq_oe [2];

  sram_seq_ctrl i_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_write(req_write[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .mem_addr(mem_addr[0]),
    .mem_cs1_n(cs1_n[0]), .mem_cs2(cs2[0]), .mem_cs3_n(cs3_n[0]), .mem_we_n(we_n[0]),
    .mem_oe_n(oe_n[0]), .mem_dq_out(mem_dq_out[0]), .mem_dq_in(mem_dq_in[0]),
    .mem_dq_oe(dq_oe[0]));

  sram_seq_ctrl #(.OE_HIGH_WRITE(1'b0)) i_sram_seq_ctrl_oel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_write(req_write[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .mem_addr(mem_addr[1]),
    .mem_cs1_n(cs1_n[1]), .mem_cs2(cs2[1]), .mem_cs3_n(cs3_n[1]), .mem_we_n(we_n[1]),
    .mem_oe_n(oe_n[1]), .mem_dq_out(mem_dq_out[1]), .mem_dq_in(mem_dq_in[1]),
    .mem_dq_oe(dq_oe[1]));

  int checks = 0;
  int errors = 0;

  function automatic int cyc(input int t);
    int c;
    c = (t + 3) / 4;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int ACC, OHZ, PP [2], GG [2], DD [2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [16:0] addr_of(input int j);
    if (j == 0) return 17'h00000;
    if (j == 1) return 17'h1FFFF;
    return 17'((j * 61907) ^ 17'h0A5A5);
  endfunction
  function automatic logic [23:0] data_of(input int j);
    if (j == 0) return 24'hFFFFFF;
    if (j == 1) return 24'h000000;
    return 24'hA5C300 ^ 24'(j * 127959);
  endfunction
  function automatic logic [23:0] dflt(input logic [16:0] a);
    return {7'h2B, a};
  endfunction

  // op list: write j / read j pairs, fresh reads, rewrites, read-backs
  task automatic op_of(input int i, output bit w, output logic [16:0] a, output logic [23:0] d);
    if (i < 16) begin
      w = (i % 2 == 0); a = addr_of(i / 2); d = data_of(i / 2);
    end else if (i < 24) begin
      w = 1'b0; a = addr_of(i); d = 24'h0;
    end else if (i < 28) begin
      w = 1'b1; a = addr_of(i - 24); d = ~data_of(i - 24);
    end else begin
      w = 1'b0; a = addr_of(i - 28); d = 24'h0;
    end
  endtask
  function automatic int gap_of(input int i);
    return (i % 3 == 0) ? 2 : 0;
  endfunction

  logic [23:0] shd [int];
  logic [23:0] mem [int];

  int          busy [2], k [2], kind_w [2], op_i [2], gap [2], quiet [2], rdcnt [2];
  bit          acc_pend [2], seen [2], prev_wl [2];
  logic [16:0] paddr [2], last_a [2];
  logic [23:0] pdata [2], exp_rd [2], prev_do [2];

  function automatic int key_of(input int u, input logic [16:0] a);
    return u * 131072 + int'(a);
  endfunction

  task automatic step(input int u);
    bit sel, rmode, e_rdy, e_we, e_oe, e_drv, e_rv, w;
    int len, kk;
    logic [16:0] a;
    logic [23:0] d, mv;
    string st;
    st = (u == 0) ? "R6" : "R7";
    // memory model
    sel   = !cs1_n[u] && cs2[u] && !cs3_n[u];
    rmode = sel && we_n[u] && !oe_n[u];
    if (prev_wl[u] && sel && we_n[u]) mem[key_of(u, mem_addr[u])] = prev_do[u];
    prev_wl[u] = sel && !we_n[u];
    prev_do[u] = mem_dq_out[u];
    if (rmode) quiet[u] = 0; else if (quiet[u] < 100) quiet[u]++;
    chk(!(dq_oe[u] && quiet[u] <= OHZ), "R9", "driver on while memory may drive", {31'd0, dq_oe[u]}, 0);
    if (rmode && mem_addr[u] == last_a[u]) rdcnt[u]++; else rdcnt[u] = rmode ? 1 : 0;
    last_a[u] = mem_addr[u];
    mv = mem.exists(key_of(u, mem_addr[u])) ? mem[key_of(u, mem_addr[u])] : dflt(mem_addr[u]);
    mem_dq_in[u] = (rdcnt[u] >= ACC) ? mv : 24'h3C3C3C;
    // reference model advance
    if (acc_pend[u]) begin
      op_of(op_i[u], w, a, d);
      busy[u] = 1; k[u] = 1; kind_w[u] = w; paddr[u] = a; pdata[u] = d; seen[u] = 1'b1;
      if (w) shd[key_of(u, a)] = d;
      else exp_rd[u] = shd.exists(key_of(u, a)) ? shd[key_of(u, a)] : dflt(a);
      op_i[u]++;
      gap[u] = gap_of(op_i[u]);
    end else if (busy[u] != 0) k[u]++;
    kk  = k[u];
    len = kind_w[u] ? (PP[u] + GG[u] + DD[u] + 2) : (ACC + 1);
    e_rdy = 1; e_we = 1; e_oe = 1; e_drv = 0; e_rv = 0;
    if (busy[u] != 0 && kk < len) begin
      e_rdy = 0;
      if (!kind_w[u]) e_oe = 0;
      else if (kk <= PP[u]) begin end
      else if (kk <= PP[u] + GG[u]) begin e_we = 0; e_oe = 0; end
      else if (kk <= PP[u] + GG[u] + DD[u]) begin e_we = 0; e_drv = 1; e_oe = (u == 0); end
      else e_drv = 1;
    end else if (busy[u] != 0 && !kind_w[u]) e_rv = 1;
    chk(req_ready[u] == e_rdy, "R4", "req_ready", {31'd0, req_ready[u]}, {31'd0, e_rdy});
    chk(we_n[u] == e_we, kind_w[u] ? st : "R3", "mem_we_n", {31'd0, we_n[u]}, {31'd0, e_we});
    chk(oe_n[u] == e_oe, kind_w[u] ? ((u == 0) ? "R5" : "R7") : "R3", "mem_oe_n",
        {31'd0, oe_n[u]}, {31'd0, e_oe});
    chk(dq_oe[u] == e_drv, st, "mem_dq_oe", {31'd0, dq_oe[u]}, {31'd0, e_drv});
    chk(rsp_valid[u] == e_rv, "R10", "rsp_valid", {31'd0, rsp_valid[u]}, {31'd0, e_rv});
    chk(sel == seen[u] && cs1_n[u] == cs3_n[u], "R2", "chip selects", {29'd0, cs1_n[u], cs2[u], cs3_n[u]},
        seen[u] ? 32'h2 : 32'h5);
    if (busy[u] != 0 && kk < len)
      chk(mem_addr[u] == paddr[u], "R8", "mem_addr", {15'd0, mem_addr[u]}, {15'd0, paddr[u]});
    if (e_drv)
      chk(mem_dq_out[u] == pdata[u], "R8", "mem_dq_out", {8'd0, mem_dq_out[u]}, {8'd0, pdata[u]});
    if (e_rv)
      chk(rsp_rdata[u] == exp_rd[u], "R10", "rsp_rdata", {8'd0, rsp_rdata[u]}, {8'd0, exp_rd[u]});
    if (busy[u] != 0 && kk >= len) busy[u] = 0;
    // next stimulus
    req_valid[u] = 1'b0;
    if (op_i[u] < NOPS) begin
      if (gap[u] > 0) gap[u]--;
      else begin
        op_of(op_i[u], w, a, d);
        req_valid[u] = 1'b1; req_write[u] = w; req_addr[u] = a; req_wdata[u] = d;
      end
    end
    acc_pend[u] = req_valid[u] && e_rdy;
  endtask

  int cycles = 0;
  bit hung = 1'b0;

  initial begin
    ACC = imax(cyc(10), cyc(5));
    OHZ = cyc(6);
    PP[0] = cyc(6); GG[0] = 0; DD[0] = imax(cyc(7), cyc(5));
    PP[1] = 0; GG[1] = imax(cyc(5), cyc(6)); DD[1] = imax(cyc(5), cyc(9) - GG[1]);
    rst_n = 1'b0;
    for (int u = 0; u < 2; u++) begin
      req_valid[u] = 0; req_write[u] = 0; req_addr[u] = '0; req_wdata[u] = '0;
      mem_dq_in[u] = '0; busy[u] = 0; k[u] = 0; kind_w[u] = 0; op_i[u] = 0; gap[u] = 0;
      quiet[u] = 100; rdcnt[u] = 0; acc_pend[u] = 0; seen[u] = 0; prev_wl[u] = 0;
      paddr[u] = '0; last_a[u] = '0; pdata[u] = '0; exp_rd[u] = '0; prev_do[u] = '0;
    end
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      // R1 reset state
      chk(cs1_n[u] && !cs2[u] && cs3_n[u], "R1", "deselected in reset",
          {29'd0, cs1_n[u], cs2[u], cs3_n[u]}, 32'h5);
      chk(we_n[u] && oe_n[u] && !dq_oe[u], "R1", "strobes in reset",
          {29'd0, we_n[u], oe_n[u], dq_oe[u]}, 32'h6);
      chk(!req_ready[u], "R1", "ready in reset", {31'd0, req_ready[u]}, 0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int u = 0; u < 2; u++)
      chk(cs1_n[u] && !cs2[u] && cs3_n[u], "R1", "deselected before first request",
          {29'd0, cs1_n[u], cs2[u], cs3_n[u]}, 32'h5);
    while (!(op_i[0] == NOPS && op_i[1] == NOPS && busy[0] == 0 && busy[1] == 0 &&
             !acc_pend[0] && !acc_pend[1])) begin
      step(0);
      step(1);
      @(negedge clk);
      cycles++;
      if (cycles > 20000) begin hung = 1'b1; break; end
    end
    if (hung) chk(1'b0, "R4", "watchdog expired", cycles, 20000);
    else repeat (4) begin step(0); step(1); @(negedge clk); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule